// File: doc/BRIEF.md
# Masked Byte Register Access over I2C

This block is an I2C bus master that runs one command at a time. A command either reads or updates a bit field inside one byte register of a target device on a two-wire bus. The command gives a slot index, a register sub-address, the upper and lower bit positions of the field and, for an update, a data byte. The 7-bit device address is not part of the command. The engine reads it from a small table of address slots, and that table is filled beforehand through a separate write port.

A read returns only the selected field, moved down to bit 0, in a result register. An update is a read-modify-write: the engine reads the current byte, replaces the bits inside the field, and writes the merged byte back. Bus timing comes from a programmable divider of the block clock. Each bit on the wire is split into four quarters. If the target refuses a byte, the command stops at once with a STOP condition and reports an error together with its completion pulse. Both bus lines are open drain. The block only pulls a line low or releases it.

Top module: `i2c_field_rmw`

## Requirements
- R1: A read command (cmd_wr = 0) puts this sequence on the bus: START, address byte {dev, 0}, sub-address, repeated START, address byte {dev, 1}, then one data byte that the master answers with NACK, then STOP. At done, rd_data holds ((byte AND mask) >> cmd_lo). SDA and SCL never change on the same clock edge.
- R2: The field mask covers bit positions cmd_lo up to cmd_hi, both included. If cmd_hi < cmd_lo the mask is empty. A read then returns 0, and an update writes the stored byte back unchanged.
- R3: An update command (cmd_wr = 1) reads the register and then writes back (old AND NOT mask) OR (cmd_wdata AND mask), using the same START / address / sub-address framing followed by the data byte and STOP. cmd_wdata is taken in place and is not shifted. An update leaves rd_data unchanged, and rd_data changes only in a cycle where done is high.
- R4: The device address comes from table slot cmd_slot, and that entry is captured on the clock edge that accepts the command. A table write in that same cycle, or at any time while the command is running, affects only later commands.
- R5: If the target does not acknowledge the address, sub-address or data byte, the master skips all remaining bytes and sends STOP. It then raises done with fail = 1. rd_data and the target register are left unchanged. fail is high only together with done.
- R6: Every quarter bit cell lasts cfg_qdiv+1 clocks. busy stays high for exactly 4·(cfg_qdiv+1)·C clocks, where C = 39 for a read, 68 for an update, 11 when the address is refused and 20 when the sub-address is refused. done is a one-cycle pulse in the first cycle after busy falls.
- R7: cmd_go is accepted only while busy is low, and that includes the cycle in which done is high. A cmd_go pulse while busy is high has no effect on the running command or on what follows.
- R8: After reset, busy, done, fail and rd_data are 0 and both bus lines are released.
- R9: While busy is low, the block pulls neither SCL nor SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_qdiv | input | DIV_W | Quarter-bit length minus one, in clocks; hold stable while busy |
| tab_we | input | 1 | Write strobe for the address table |
| tab_slot | input | SW | Table slot to write |
| tab_dev | input | 7 | 7-bit device address to store |
| cmd_go | input | 1 | Start a command (taken when idle) |
| cmd_wr | input | 1 | 1 = field update, 0 = field read |
| cmd_slot | input | SW | Address table slot to use |
| cmd_sub | input | 8 | Register sub-address inside the device |
| cmd_hi | input | 3 | Upper bit position of the field |
| cmd_lo | input | 3 | Lower bit position of the field |
| cmd_wdata | input | 8 | New bit values for an update, in place |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Missing acknowledge, valid with done |
| rd_data | output | 8 | Result register of the last successful read |
| scl_pull | output | 1 | 1 = pull SCL low, 0 = release |
| sda_pull | output | 1 | 1 = pull SDA low, 0 = release |
| sda_in | input | 1 | Level seen on the SDA line |

## Verification
Two functions can fall in the same cycle. The first pair is the acceptance of a command and a write to the address table: the bench writes a new address into the slot on the very edge that accepts a command for that slot, and again in the middle of a command. It then judges, from the target model's register contents and from rd_data, that the captured old address was used and that the next command uses the new one. The second pair is the completion pulse and the next acceptance: each command is launched in the cycle where done of the previous one is high. A cycle-accurate reference model predicts busy and done on every clock, so a lost or delayed acceptance shows up at once.

// File: rtl/i2c_field_rmw.sv
module i2c_field_rmw #(
  parameter int NSLOT = 4,
  parameter int DIV_W = 8,
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_qdiv,
  input  logic             tab_we,
  input  logic [SW-1:0]    tab_slot,
  input  logic [6:0]       tab_dev,
  input  logic             cmd_go,
  input  logic             cmd_wr,
  input  logic [SW-1:0]    cmd_slot,
  input  logic [7:0]       cmd_sub,
  input  logic [2:0]       cmd_hi,
  input  logic [2:0]       cmd_lo,
  input  logic [7:0]       cmd_wdata,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic [7:0]       rd_data,
  output logic             scl_pull,
  output logic             sda_pull,
  input  logic             sda_in
);

  typedef enum logic [1:0] {OP_START, OP_TX, OP_RX, OP_STOP} op_t;

  logic [6:0]       dev_tab [NSLOT];
  logic [DIV_W-1:0] qcnt;
  logic [1:0]       q;
  logic [3:0]       bi, pc, pc_inc;
  logic [7:0]       sr, cur, nxt_byte, mask, merged, field;
  logic             wr_q, nack, err_q;
  logic [6:0]       dev_q;
  logic [7:0]       sub_q, wd_q;
  logic [2:0]       hi_q, lo_q;
  op_t              op;
  logic             tick, bitcell, v1, v3, last_stop, scl_nxt, sda_nxt;

  assign mask    = (8'hFF << lo_q) & (8'hFF >> (3'd7 - hi_q));
  assign merged  = (cur & ~mask) | (wd_q & mask);
  assign field   = (cur & mask) >> lo_q;
  assign tick    = busy && (qcnt == cfg_qdiv);
  assign pc_inc  = pc + 4'd1;
  assign bitcell = (op == OP_TX) || (op == OP_RX);
  assign last_stop = (op == OP_STOP) && (err_q || pc == 4'd11 || (pc == 4'd6 && !wr_q));

  always_comb begin
    case (pc)
      4'd0, 4'd3, 4'd7: op = OP_START;
      4'd5:             op = OP_RX;
      4'd6, 4'd11:      op = OP_STOP;
      default:          op = OP_TX;
    endcase
  end

  always_comb begin
    case (pc_inc)
      4'd1, 4'd8: nxt_byte = {dev_q, 1'b0};
      4'd4:       nxt_byte = {dev_q, 1'b1};
      4'd2, 4'd9: nxt_byte = sub_q;
      4'd10:      nxt_byte = merged;
      default:    nxt_byte = 8'h00;
    endcase
  end

  always_comb begin
    case (op)
      OP_START: begin v1 = 1'b0; v3 = 1'b1; end
      OP_STOP:  begin v1 = 1'b1; v3 = 1'b0; end
      OP_TX:    begin v1 = (bi != 4'd8) && !sr[7]; v3 = v1; end
      default:  begin v1 = 1'b0; v3 = 1'b0; end
    endcase
  end

  assign scl_nxt = busy && !q[1];
  assign sda_nxt = !busy ? 1'b0 : (q == 2'd0) ? sda_pull : (q == 2'd3) ? v3 : v1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pull <= 1'b0;
      sda_pull <= 1'b0;
    end else begin
      scl_pull <= scl_nxt;
      sda_pull <= sda_nxt;
    end
  end

  assert_sda_scl_apart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull != $past(scl_pull)) |-> (sda_pull == $past(sda_pull)));
  assert_idle_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_pull && !sda_pull));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) dev_tab[i] <= '0;
      busy <= 1'b0;  done <= 1'b0;  fail <= 1'b0;  rd_data <= '0;
      qcnt <= '0;  q <= '0;  bi <= '0;  pc <= '0;
      sr <= '0;  cur <= '0;  wr_q <= 1'b0;  nack <= 1'b0;  err_q <= 1'b0;
      dev_q <= '0;  sub_q <= '0;  wd_q <= '0;  hi_q <= '0;  lo_q <= '0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      if (tab_we) dev_tab[tab_slot] <= tab_dev;
      if (!busy) begin
        if (cmd_go) begin
          busy  <= 1'b1;
          pc    <= '0;  q <= '0;  qcnt <= '0;  bi <= '0;
          err_q <= 1'b0;  nack <= 1'b0;
          wr_q  <= cmd_wr;
          dev_q <= dev_tab[cmd_slot];
          sub_q <= cmd_sub;  wd_q <= cmd_wdata;
          hi_q  <= cmd_hi;   lo_q <= cmd_lo;
        end
      end else begin
        qcnt <= tick ? '0 : qcnt + 1'b1;
        if (tick) begin
          q <= q + 2'd1;
          if (q == 2'd2 && bitcell) begin
            if (bi == 4'd8)        nack <= (op == OP_TX) && sda_in;
            else if (op == OP_RX)  sr   <= {sr[6:0], sda_in};
          end
          if (q == 2'd3) begin
            if (bitcell) begin
              if (bi != 4'd8) begin
                bi <= bi + 4'd1;
                if (op == OP_TX) sr <= {sr[6:0], 1'b0};
              end else begin
                bi <= '0;
                if (op == OP_RX) cur <= sr;
                if (nack) begin
                  err_q <= 1'b1;
                  pc    <= 4'd6;
                end else begin
                  pc <= pc_inc;
                  sr <= nxt_byte;
                end
              end
            end else if (last_stop) begin
              busy <= 1'b0;
              done <= 1'b1;
              fail <= err_q;
              if (!err_q && !wr_q) rd_data <= field;
            end else begin
              pc <= pc_inc;
              sr <= nxt_byte;
            end
          end
        end
      end
    end
  end

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_fail_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (done && !busy));
  assert_accept_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_go) |=> busy);
  assert_result_at_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data != $past(rd_data)) |-> done);

endmodule

// File: tb/tb_i2c_field_rmw.sv
`timescale 1ns/1ps
module tb_i2c_field_rmw;
  localparam int NSLOT = 4;
  localparam int DIV_W = 8;
  localparam int SW = 2;
  localparam logic [6:0] DEV0 = 7'h3C;
  localparam logic [6:0] DEV1 = 7'h51;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [DIV_W-1:0] cfg_qdiv = 8'd2;
  logic tab_we = 1'b0;
  logic [SW-1:0] tab_slot = '0;
  logic [6:0] tab_dev = '0;
  logic cmd_go = 1'b0, cmd_wr = 1'b0;
  logic [SW-1:0] cmd_slot = '0;
  logic [7:0] cmd_sub = '0, cmd_wdata = '0;
  logic [2:0] cmd_hi = '0, cmd_lo = '0;
  logic busy, done, fail, scl_pull, sda_pull;
  logic [7:0] rd_data;

  logic s_drv = 1'b0;
  wire scl_line = !scl_pull;
  wire sda_line = !(sda_pull || s_drv);

  i2c_field_rmw #(.NSLOT(NSLOT), .DIV_W(DIV_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_qdiv(cfg_qdiv),
    .tab_we(tab_we), .tab_slot(tab_slot), .tab_dev(tab_dev),
    .cmd_go(cmd_go), .cmd_wr(cmd_wr), .cmd_slot(cmd_slot), .cmd_sub(cmd_sub),
    .cmd_hi(cmd_hi), .cmd_lo(cmd_lo), .cmd_wdata(cmd_wdata),
    .busy(busy), .done(done), .fail(fail), .rd_data(rd_data),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .sda_in(sda_line));

  int n_chk = 0, n_bad = 0;
  function automatic void chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endfunction

  // target device model with two register files
  logic [7:0] mem [0:1][0:255];
  logic [7:0] ref_mem [0:1][0:255];
  logic [6:0] tab_ref [NSLOT];
  bit nack_sub = 0, nack_data = 0;
  bit s_idle = 1, tx = 0, rw = 0, mack = 0;
  int bc = 0, bytn = 0, dsel = 0;
  logic [7:0] sh = '0, ptr = '0;

  always @(negedge sda_line) if (scl_line) begin
    s_idle = 0; bc = 0; bytn = 0; tx = 0; s_drv = 0;
  end
  always @(posedge sda_line) if (scl_line) begin
    s_idle = 1; s_drv = 0;
  end
  always @(posedge scl_line) if (!s_idle) begin
    if (bc < 8) begin
      if (!tx) sh = {sh[6:0], sda_line};
      bc++;
    end else if (bc == 8) begin
      if (tx) mack = !sda_line;
      bc = 9;
    end
  end
  always @(negedge scl_line) if (!s_idle) begin
    if (bc == 8) begin
      if (tx) s_drv = 0;
      else if (bytn == 0) begin
        if (sh[7:1] == DEV0)      begin dsel = 0; rw = sh[0]; s_drv = 1; end
        else if (sh[7:1] == DEV1) begin dsel = 1; rw = sh[0]; s_drv = 1; end
        else begin s_drv = 0; s_idle = 1; end
      end else if (bytn == 1) begin
        if (nack_sub) begin s_drv = 0; s_idle = 1; end
        else begin ptr = sh; s_drv = 1; end
      end else begin
        if (nack_data) begin s_drv = 0; s_idle = 1; end
        else begin mem[dsel][ptr] = sh; ptr++; s_drv = 1; end
      end
    end else if (bc == 9) begin
      bc = 0;
      s_drv = 0;
      if (tx) s_idle = 1;
      else begin
        bytn++;
        if (bytn == 1 && rw) begin tx = 1; sh = mem[dsel][ptr]; s_drv = !sh[7]; end
      end
    end else if (tx && bc > 0 && bc < 8) s_drv = !sh[7-bc];
  end

  // cycle model of busy and done
  bit m_busy = 0, m_done = 0, mon_on = 0;
  int m_left = 0, m_cells = 0;
  always @(posedge clk) begin
    if (!rst_n) begin m_busy = 0; m_done = 0; end
    else if (m_busy) begin
      m_left--; m_done = 0;
      if (m_left == 0) begin m_busy = 0; m_done = 1; end
    end else begin
      m_done = 0;
      if (cmd_go) begin m_busy = 1; m_left = m_cells * 4 * (int'(cfg_qdiv) + 1); end
    end
  end
  always @(negedge clk) if (mon_on) begin
    chk(busy === m_busy, "R6", "busy", busy, m_busy);
    chk(done === m_done, "R6", "done", done, m_done);
  end

  logic [7:0] exp_rd = '0;

  task automatic prog(input int slot, input logic [6:0] dv);
    tab_we = 1; tab_slot = SW'(slot); tab_dev = dv;
    @(negedge clk);
    tab_we = 0;
    tab_ref[slot] = dv;
  endtask

  task automatic run(input bit wr, input int slot, input logic [7:0] sub,
                     input logic [2:0] hi, input logic [2:0] lo,
                     input logic [7:0] wd, input string req);
    logic [6:0] dv;
    logic [7:0] msk, old;
    bit present, ef;
    int ds, cells;
    dv = tab_ref[slot];
    present = (dv == DEV0) || (dv == DEV1);
    ds = (dv == DEV1) ? 1 : 0;
    msk = '0;
    for (int i = 0; i < 8; i++) if (i >= int'(lo) && i <= int'(hi)) msk[i] = 1'b1;
    old = ref_mem[ds][sub];
    if (!present)     begin cells = 11; ef = 1; end
    else if (nack_sub) begin cells = 20; ef = 1; end
    else if (wr)      begin cells = 68; ef = nack_data; end
    else              begin cells = 39; ef = 0; end
    m_cells = cells;
    cmd_wr = wr; cmd_slot = SW'(slot); cmd_sub = sub; cmd_hi = hi; cmd_lo = lo;
    cmd_wdata = wd; cmd_go = 1;
    @(negedge clk);
    cmd_go = 0; tab_we = 0;
    while (!done) @(negedge clk);
    if (!ef && !wr) exp_rd = (old & msk) >> lo;
    if (!ef && wr) ref_mem[ds][sub] = (old & ~msk) | (wd & msk);
    chk(fail == ef, req, "fail", fail, ef);
    chk(rd_data == exp_rd, req, "rd_data", rd_data, exp_rd);
    if (present) chk(mem[ds][sub] == ref_mem[ds][sub], req, "target byte", mem[ds][sub], ref_mem[ds][sub]);
    chk(!scl_pull && !sda_pull, "R9", "lines at done", {scl_pull, sda_pull}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R6 watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int d = 0; d < 2; d++)
      for (int a = 0; a < 256; a++) begin
        mem[d][a] = 8'(a * 37 + d * 91 + 5);
        ref_mem[d][a] = mem[d][a];
      end
    for (int i = 0; i < NSLOT; i++) tab_ref[i] = '0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(busy == 0 && done == 0 && fail == 0, "R8", "flags", {busy, done, fail}, 0);
    chk(rd_data == 0, "R8", "rd_data", rd_data, 0);
    chk(!scl_pull && !sda_pull, "R8", "lines", {scl_pull, sda_pull}, 0);
    rst_n = 1; mon_on = 1;
    @(negedge clk);
    prog(0, DEV0); prog(1, DEV1); prog(2, 7'h22); prog(3, DEV0);

    run(0, 0, 8'h10, 3'd7, 3'd0, 8'h00, "R1");
    run(0, 1, 8'h33, 3'd5, 3'd2, 8'h00, "R1");
    run(0, 0, 8'h44, 3'd2, 3'd5, 8'h00, "R2");
    run(1, 0, 8'h10, 3'd6, 3'd3, 8'hA5, "R3");
    run(0, 0, 8'h10, 3'd7, 3'd0, 8'h00, "R3");
    run(1, 1, 8'h20, 3'd1, 3'd4, 8'hFF, "R2");
    run(1, 1, 8'h21, 3'd7, 3'd7, 8'h80, "R3");
    run(0, 1, 8'h21, 3'd7, 3'd7, 8'h00, "R3");
    run(0, 2, 8'h10, 3'd7, 3'd0, 8'h00, "R5");
    nack_sub = 1;
    run(0, 0, 8'h11, 3'd7, 3'd0, 8'h00, "R5");
    nack_sub = 0; nack_data = 1;
    run(1, 0, 8'h12, 3'd7, 3'd0, 8'h5A, "R5");
    nack_data = 0;

    cfg_qdiv = 8'd0;
    run(0, 1, 8'hF0, 3'd3, 3'd0, 8'h00, "R6");
    cfg_qdiv = 8'd5;
    run(1, 0, 8'h7E, 3'd4, 3'd1, 8'h0F, "R6");
    cfg_qdiv = 8'd1;

    // R7: start pulse while busy with other fields
    fork
      run(1, 1, 8'h30, 3'd3, 3'd0, 8'h09, "R7");
      begin
        repeat (50) @(negedge clk);
        cmd_wr = 0; cmd_slot = 2'd0; cmd_sub = 8'h99; cmd_hi = 3'd7; cmd_lo = 3'd0; cmd_go = 1;
        @(negedge clk);
        cmd_go = 0;
      end
    join
    run(0, 1, 8'h30, 3'd7, 3'd0, 8'h00, "R7");

    // R4: table rewrite during a running command
    fork
      run(0, 3, 8'h55, 3'd7, 3'd0, 8'h00, "R4");
      begin
        repeat (40) @(negedge clk);
        tab_we = 1; tab_slot = 2'd3; tab_dev = DEV1;
        @(negedge clk);
        tab_we = 0;
      end
    join
    tab_ref[3] = DEV1;
    run(0, 3, 8'h55, 3'd7, 3'd0, 8'h00, "R4");

    // R4: table write in the same cycle as acceptance
    tab_we = 1; tab_slot = 2'd0; tab_dev = DEV1;
    run(0, 0, 8'h66, 3'd7, 3'd0, 8'h00, "R4");
    tab_ref[0] = DEV1;
    run(0, 0, 8'h66, 3'd7, 3'd0, 8'h00, "R4");

    repeat (5) @(negedge clk);
    mon_on = 0;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule